// File: doc/BRIEF.md
# Guarded code-memory erase and program sequencer

This block sits between a host register bus and an abstract code-memory array and decides when an erase or a program cycle may start. The host sees four byte-wide write locations: a control register, a key register, a mode register and a data port. Program bytes written through the data port go into small per-panel staging buffers. The byte's panel and its place inside the panel come from the table-pointer input. An operation is requested by setting the start bit in the control register. That request is honoured only when a strict key sequence has just been written, the enable bit was already on, and the select bits point at code memory.

An accepted request is not sent to the array at once. The block counts falling edges of the programming serial clock and pulses the array start on the fourth one. It then holds the start bit until the array returns done. After done, it waits through a discharge period before it accepts any further register traffic. Erase works on one aligned 64-byte block. Programming works either on the single 8-byte panel picked by the pointer, or on every fully loaded panel of an aligned group at once. Every refused request sets a sticky error flag.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the control register reads 0x00, the error flag is 0, no array start is pulsed, and multi-panel mode is selected (mode register bit 0 = 1).
- R2: A control write with bit 1 (start) set is accepted only if the two key-register writes just before it were 0x55 and then 0xAA. A refused start leaves bit 1 at 0, launches nothing and sets the error flag.
- R3: A write to any other location between the key pair and the start write voids the key, and so does a key value out of order. The start that follows is refused and flagged.
- R4: The enable bit (control bit 2) must already be 1 before the start write. If it is not, the start is refused and flagged, while the other written control bits are still stored.
- R5: A start is refused and flagged unless the written value has memory-select (bit 7) = 1 and configuration-select (bit 6) = 0.
- R6: With erase-select (bit 4) set, an accepted start issues an erase: arrErase = 1, an empty panel mask, and arrAddr equal to the table pointer rounded down to a 64-byte boundary.
- R7: In single-panel mode (mode bit 0 = 0), a program start needs the panel at pointer bits [4:3] to hold all 8 bytes. It then writes only that panel, at the pointer rounded down to 8 bytes, with the staged bytes. Written panels count as empty afterwards.
- R8: In multi-panel mode, a program start writes every full panel of the 32-byte group around the pointer, at the pointer rounded down to 32 bytes. It is refused and flagged if no panel is full or if any panel is partly loaded.
- R9: The array start pulse comes after the fourth falling edge of the serial clock that follows acceptance, never after the third. It lasts one cycle.
- R10: The start bit stays 1 until the array reports done and is then cleared by the block. All register writes made before done are ignored.
- R11: After done, every register write is ignored for the discharge period. After that period, writes take effect again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe, one cycle per write |
| regAddr | input | 2 | Location: 0 control, 1 key, 2 mode, 3 data port |
| regWrData | input | 8 | Host write data |
| tblPtr | input | ADDR_W | Table pointer: byte address for data writes and operations |
| sclk | input | 1 | Programming serial clock, sampled by clk |
| arrDone | input | 1 | One-cycle completion pulse from the array |
| ctlReg | output | 8 | Current control register value |
| errFlag | output | 1 | Sticky refusal flag |
| arrStart | output | 1 | One-cycle operation launch |
| arrErase | output | 1 | 1 for erase, 0 for program |
| arrAddr | output | ADDR_W | Aligned operation address |
| arrMask | output | NUM_PANELS | Panels to program |
| arrData | output | NUM_PANELS*PANEL_BYTES*8 | Staged panel bytes, panel 0 byte 0 in the low byte |

## Verification
The bench builds the block with four 8-byte panels, a 12-bit pointer and a discharge period of 20 cycles in place of the long default. With that short period, the ignored-write window and the return to normal behaviour both fit inside one directed test. The serial clock is driven by the bench edge by edge, so the third and the fourth falling edge can each be checked. Pointer values are chosen off alignment, so that the 64-, 32- and 8-byte rounding each produce a distinct address.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  // host register locations
  localparam logic [1:0] REG_CTL  = 2'd0;
  localparam logic [1:0] REG_KEY  = 2'd1;
  localparam logic [1:0] REG_MODE = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  // control register bit positions
  localparam int BIT_MEM   = 7;
  localparam int BIT_CFG   = 6;
  localparam int BIT_ERASE = 4;
  localparam int BIT_WREN  = 2;
  localparam int BIT_START = 1;
  localparam logic [7:0] CTL_RW_MASK = 8'hD4;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {PH_IDLE, PH_ARM, PH_BUSY, PH_DRAIN} phase_t;
  typedef enum logic [1:0] {KEY_NONE, KEY_HALF, KEY_OPEN} keyState_t;

  typedef struct packed {
    logic loadByte;   // store regWrData at the pointed buffer slot
    logic capture;    // latch operation kind, address and mask
    logic freeBufs;   // mark the written panels empty
  } dpStrobe_t;
endpackage

// File: rtl/flash_prog_data.sv
module flash_prog_data
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_PANELS  = 4,
  parameter int PANEL_BYTES = 8,
  parameter int ERASE_BYTES = 64
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpStrobe_t                         strobe,
  input  logic [7:0]                        byteIn,
  input  logic [ADDR_W-1:0]                 tblPtr,
  input  logic                              eraseSel,
  input  logic                              multiSel,
  output logic                              wrReady,
  output logic                              opErase,
  output logic [ADDR_W-1:0]                 opAddr,
  output logic [NUM_PANELS-1:0]             opMask,
  output logic [NUM_PANELS*PANEL_BYTES*8-1:0] opData
);
  localparam int OFF_W  = $clog2(PANEL_BYTES);
  localparam int PAN_W  = $clog2(NUM_PANELS);
  localparam int SLOTS  = NUM_PANELS * PANEL_BYTES;
  localparam logic [ADDR_W-1:0] ERASE_LOW = ADDR_W'(ERASE_BYTES - 1);
  localparam logic [ADDR_W-1:0] GROUP_LOW = ADDR_W'(SLOTS - 1);
  localparam logic [ADDR_W-1:0] PANEL_LOW = ADDR_W'(PANEL_BYTES - 1);

  logic [SLOTS*8-1:0]    bufMem;
  logic [SLOTS-1:0]      validBits;
  logic [NUM_PANELS-1:0] fullMask, partMask, selMask, wantMask;
  logic [OFF_W-1:0]      curOff;
  logic [PAN_W-1:0]      curPanel;

  assign curOff   = tblPtr[OFF_W-1:0];
  assign curPanel = tblPtr[OFF_W +: PAN_W];

  for (genvar p = 0; p < NUM_PANELS; p++) begin : g_panel
    assign fullMask[p] = &validBits[p*PANEL_BYTES +: PANEL_BYTES];
    assign partMask[p] = (|validBits[p*PANEL_BYTES +: PANEL_BYTES]) & ~fullMask[p];
    assign selMask[p]  = (curPanel == PAN_W'(p));
  end

  assign wantMask = multiSel ? fullMask : (selMask & fullMask);
  assign wrReady  = multiSel ? ((|fullMask) && !(|partMask)) : (|(selMask & fullMask));
  assign opData   = bufMem;

  always_ff @(posedge clk) begin
    if (strobe.loadByte)
      bufMem[{curPanel, curOff}*8 +: 8] <= byteIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      opErase   <= 1'b0;
      opAddr    <= '0;
      opMask    <= '0;
    end else begin
      if (strobe.loadByte)
        validBits[{curPanel, curOff}] <= 1'b1;
      if (strobe.freeBufs) begin
        for (int p = 0; p < NUM_PANELS; p++)
          if (opMask[p]) validBits[p*PANEL_BYTES +: PANEL_BYTES] <= '0;
      end
      if (strobe.capture) begin
        opErase <= eraseSel;
        opMask  <= eraseSel ? '0 : wantMask;
        if (eraseSel)      opAddr <= tblPtr & ~ERASE_LOW;
        else if (multiSel) opAddr <= tblPtr & ~GROUP_LOW;
        else               opAddr <= tblPtr & ~PANEL_LOW;
      end
    end
  end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int SCLK_EDGES   = 4,
  parameter int DRAIN_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       sclk,
  input  logic       arrDone,
  input  logic       wrReady,
  output logic [7:0] ctlReg,
  output logic       multiSel,
  output logic       errFlag,
  output logic       arrStart,
  output dpStrobe_t  strobe
);
  localparam int EDGE_W  = $clog2(SCLK_EDGES + 1);
  localparam int DRAIN_W = $clog2(DRAIN_CYCLES + 1);

  phase_t             phase;
  keyState_t          keyState;
  logic [EDGE_W-1:0]  edgeCnt;
  logic [DRAIN_W-1:0] drainCnt;
  logic               sclkQ, sclkFall;
  logic               hostWr, startReq, startOk;

  assign sclkFall = sclkQ & ~sclk;
  assign hostWr   = (phase == PH_IDLE) && regWrEn;
  assign startReq = hostWr && (regAddr == REG_CTL) && regWrData[BIT_START];
  assign startOk  = (keyState == KEY_OPEN) && ctlReg[BIT_WREN] &&
                    regWrData[BIT_MEM] && !regWrData[BIT_CFG] &&
                    (regWrData[BIT_ERASE] || wrReady);

  always_comb begin
    strobe.loadByte = hostWr && (regAddr == REG_DATA);
    strobe.capture  = startReq && startOk;
    strobe.freeBufs = (phase == PH_BUSY) && arrDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg   <= '0;
      multiSel <= 1'b1;
      errFlag  <= 1'b0;
      keyState <= KEY_NONE;
      phase    <= PH_IDLE;
      edgeCnt  <= '0;
      drainCnt <= '0;
      arrStart <= 1'b0;
      sclkQ    <= 1'b0;
    end else begin
      sclkQ    <= sclk;
      arrStart <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (regWrEn) begin
            keyState <= KEY_NONE;
            unique case (regAddr)
              REG_KEY: begin
                if (regWrData == KEY_FIRST)
                  keyState <= KEY_HALF;
                else if (keyState == KEY_HALF && regWrData == KEY_SECOND)
                  keyState <= KEY_OPEN;
              end
              REG_MODE: multiSel <= regWrData[0];
              REG_CTL: begin
                ctlReg <= regWrData & CTL_RW_MASK;
                if (startReq) begin
                  if (startOk) begin
                    ctlReg[BIT_START] <= 1'b1;
                    phase   <= PH_ARM;
                    edgeCnt <= '0;
                  end else begin
                    errFlag <= 1'b1;
                  end
                end
              end
              default: ;
            endcase
          end
        end
        PH_ARM: begin
          if (sclkFall) begin
            if (edgeCnt == EDGE_W'(SCLK_EDGES - 1)) begin
              arrStart <= 1'b1;
              phase    <= PH_BUSY;
            end else begin
              edgeCnt <= edgeCnt + 1'b1;
            end
          end
        end
        PH_BUSY: begin
          if (arrDone) begin
            ctlReg[BIT_START] <= 1'b0;
            phase    <= PH_DRAIN;
            drainCnt <= DRAIN_W'(DRAIN_CYCLES - 1);
          end
        end
        PH_DRAIN: begin
          if (drainCnt == '0) phase <= PH_IDLE;
          else                drainCnt <= drainCnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int NUM_PANELS   = 4,
  parameter int PANEL_BYTES  = 8,
  parameter int ERASE_BYTES  = 64,
  parameter int SCLK_EDGES   = 4,
  parameter int DRAIN_CYCLES = 1000
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                regWrEn,
  input  logic [1:0]                          regAddr,
  input  logic [7:0]                          regWrData,
  input  logic [ADDR_W-1:0]                   tblPtr,
  input  logic                                sclk,
  input  logic                                arrDone,
  output logic [7:0]                          ctlReg,
  output logic                                errFlag,
  output logic                                arrStart,
  output logic                                arrErase,
  output logic [ADDR_W-1:0]                   arrAddr,
  output logic [NUM_PANELS-1:0]               arrMask,
  output logic [NUM_PANELS*PANEL_BYTES*8-1:0] arrData
);
  dpStrobe_t strobe;
  logic      multiSel, wrReady;

  flash_prog_ctrl #(
    .SCLK_EDGES(SCLK_EDGES), .DRAIN_CYCLES(DRAIN_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .sclk(sclk), .arrDone(arrDone), .wrReady(wrReady),
    .ctlReg(ctlReg), .multiSel(multiSel), .errFlag(errFlag),
    .arrStart(arrStart), .strobe(strobe)
  );

  flash_prog_data #(
    .ADDR_W(ADDR_W), .NUM_PANELS(NUM_PANELS),
    .PANEL_BYTES(PANEL_BYTES), .ERASE_BYTES(ERASE_BYTES)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIn(regWrData),
    .tblPtr(tblPtr), .eraseSel(regWrData[BIT_ERASE]), .multiSel(multiSel),
    .wrReady(wrReady), .opErase(arrErase), .opAddr(arrAddr),
    .opMask(arrMask), .opData(arrData)
  );
endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
  parameter int ADDR_W      = 16,
  parameter int NUM_PANELS  = 4,
  parameter int ERASE_BYTES = 64
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic [1:0]            regAddr,
  input logic                  wrStartBit,
  input logic [7:0]            ctlReg,
  input logic                  arrStart,
  input logic                  arrErase,
  input logic [ADDR_W-1:0]     arrAddr,
  input logic [NUM_PANELS-1:0] arrMask,
  input logic                  arrDone
);
  localparam logic [ADDR_W-1:0] ERASE_LOW = ADDR_W'(ERASE_BYTES - 1);

  AST_START_FROM_CTL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlReg[1]) |-> $past(regWrEn) && $past(regAddr) == 2'd0 && $past(wrStartBit)); // R2
  AST_LAUNCH_CODE_MEM: assert property (@(posedge clk) disable iff (!rstN)
    arrStart |-> ctlReg[7] && !ctlReg[6] && ctlReg[1]); // R5
  AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    arrStart && arrErase |-> (arrAddr & ERASE_LOW) == '0 && arrMask == '0); // R6
  AST_PROGRAM_HAS_PANEL: assert property (@(posedge clk) disable iff (!rstN)
    arrStart && !arrErase |-> arrMask != '0); // R7
  AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    arrStart |=> !arrStart); // R9
  AST_START_CLEARS_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlReg[1]) |-> $past(arrDone)); // R10
  AST_CTL_FROZEN_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[1] && $past(ctlReg[1]) |-> $stable(ctlReg)); // R10
endmodule

bind flash_prog_seq flash_prog_chk #(
  .ADDR_W(ADDR_W), .NUM_PANELS(NUM_PANELS), .ERASE_BYTES(ERASE_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .wrStartBit(regWrData[1]), .ctlReg(ctlReg), .arrStart(arrStart),
  .arrErase(arrErase), .arrAddr(arrAddr), .arrMask(arrMask), .arrDone(arrDone)
);

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
  localparam int ADDR_W = 12, NP = 4, PB = 8, DRAIN = 20;

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, sclk = 1'b0, arrDone = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [ADDR_W-1:0] tblPtr = '0;
  logic [7:0] ctlReg;
  logic errFlag, arrStart, arrErase;
  logic [ADDR_W-1:0] arrAddr;
  logic [NP-1:0] arrMask;
  logic [NP*PB*8-1:0] arrData;

  int checks = 0, fails = 0, startCnt = 0;
  logic capErase;
  logic [ADDR_W-1:0] capAddr;
  logic [NP-1:0] capMask;
  logic [NP*PB*8-1:0] capData;

  always #10 clk = ~clk;

  flash_prog_seq #(.ADDR_W(ADDR_W), .NUM_PANELS(NP), .PANEL_BYTES(PB),
    .ERASE_BYTES(64), .SCLK_EDGES(4), .DRAIN_CYCLES(DRAIN)) dut (.*);

  always @(posedge clk) if (rstN && arrStart) begin
    startCnt++;
    capErase = arrErase; capAddr = arrAddr; capMask = arrMask; capData = arrData;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; regWrEn = 1'b0; sclk = 1'b0; arrDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic regWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic unlockKeys();
    regWrite(2'd1, 8'h55); regWrite(2'd1, 8'hAA);
  endtask

  function automatic logic [7:0] pat(int slot);
    return 8'hA0 ^ 8'(slot * 7);
  endfunction

  task automatic loadPanel(logic [ADDR_W-1:0] groupBase, int panel, int count);
    for (int i = 0; i < count; i++) begin
      tblPtr = groupBase + ADDR_W'(panel * PB + i);
      regWrite(2'd3, pat(panel * PB + i));
    end
  endtask

  task automatic sclkFalls(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1'b1; repeat (2) @(negedge clk);
      sclk = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic finishOp();
    repeat (3) @(negedge clk);
    arrDone = 1'b1; @(negedge clk); arrDone = 1'b0;
    repeat (DRAIN + 5) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 ctlReg", 32'(ctlReg), 0);
    chk("R1 errFlag", 32'(errFlag), 0);
    chk("R1 arrStart", 32'(arrStart), 0);
  endtask

  task automatic testEraseFlow();
    int base;
    doReset(); base = startCnt;
    regWrite(2'd0, 8'h84); unlockKeys();
    tblPtr = 12'h1A7;
    regWrite(2'd0, 8'h96);
    chk("R2 start accepted", 32'(ctlReg), 32'h96);
    chk("R2 no error", 32'(errFlag), 0);
    sclkFalls(3);
    chk("R9 no launch after third edge", 32'(startCnt - base), 0);
    sclkFalls(1);
    chk("R9 launch after fourth edge", 32'(startCnt - base), 1);
    chk("R6 erase kind", 32'(capErase), 1);
    chk("R6 erase address", 32'(capAddr), 32'h180);
    chk("R6 erase mask", 32'(capMask), 0);
    regWrite(2'd0, 8'h00);
    chk("R10 write ignored while busy", 32'(ctlReg), 32'h96);
    repeat (2) @(negedge clk);
    arrDone = 1'b1; @(negedge clk); arrDone = 1'b0; @(negedge clk);
    chk("R10 start cleared on done", 32'(ctlReg), 32'h94);
    regWrite(2'd0, 8'h00);
    chk("R11 write ignored during discharge", 32'(ctlReg), 32'h94);
    repeat (DRAIN + 5) @(negedge clk);
    regWrite(2'd0, 8'h80);
    chk("R11 write accepted after discharge", 32'(ctlReg), 32'h80);
  endtask

  task automatic testNoKey();
    int base;
    doReset(); base = startCnt;
    regWrite(2'd0, 8'h84);
    regWrite(2'd0, 8'h96);
    chk("R2 start without key refused", 32'(ctlReg[1]), 0);
    chk("R2 error set", 32'(errFlag), 1);
    sclkFalls(4);
    chk("R2 nothing launched", 32'(startCnt - base), 0);
  endtask

  task automatic testBrokenKey();
    doReset();
    regWrite(2'd0, 8'h84); unlockKeys(); regWrite(2'd2, 8'h01);
    regWrite(2'd0, 8'h96);
    chk("R3 intervening access voids key", 32'({ctlReg[1], errFlag}), 32'h1);
    doReset();
    regWrite(2'd0, 8'h84);
    regWrite(2'd1, 8'hAA); regWrite(2'd1, 8'h55);
    regWrite(2'd0, 8'h96);
    chk("R3 reversed key refused", 32'({ctlReg[1], errFlag}), 32'h1);
  endtask

  task automatic testEnableOrder();
    doReset(); unlockKeys();
    regWrite(2'd0, 8'h96);
    chk("R4 enable not set before", 32'(ctlReg), 32'h94);
    chk("R4 error set", 32'(errFlag), 1);
  endtask

  task automatic testSelects();
    doReset(); regWrite(2'd0, 8'h84); unlockKeys();
    regWrite(2'd0, 8'hD6);
    chk("R5 config select refused", 32'({ctlReg[1], errFlag}), 32'h1);
    doReset(); regWrite(2'd0, 8'h84); unlockKeys();
    regWrite(2'd0, 8'h16);
    chk("R5 memory select clear refused", 32'({ctlReg[1], errFlag}), 32'h1);
  endtask

  task automatic testSinglePanel();
    int base;
    doReset(); base = startCnt;
    regWrite(2'd2, 8'h00);
    loadPanel(12'h240, 2, PB);
    tblPtr = 12'h253;
    regWrite(2'd0, 8'h84); unlockKeys(); regWrite(2'd0, 8'h86);
    chk("R7 single start accepted", 32'({ctlReg[1], errFlag}), 32'h2);
    sclkFalls(4);
    chk("R7 one launch", 32'(startCnt - base), 1);
    chk("R7 program kind", 32'(capErase), 0);
    chk("R7 panel mask", 32'(capMask), 32'h4);
    chk("R7 panel address", 32'(capAddr), 32'h250);
    chk("R7 staged byte", 32'(capData[(2*PB+3)*8 +: 8]), 32'(pat(2*PB+3)));
    finishOp();
    unlockKeys(); regWrite(2'd0, 8'h86);
    chk("R7 emptied panel refused", 32'({ctlReg[1], errFlag}), 32'h1);
  endtask

  task automatic testMultiPanel();
    int base;
    doReset(); base = startCnt;
    loadPanel(12'h300, 0, PB); loadPanel(12'h300, 3, PB);
    tblPtr = 12'h315;
    regWrite(2'd0, 8'h84); unlockKeys(); regWrite(2'd0, 8'h86);
    sclkFalls(4);
    chk("R8 multi launch", 32'(startCnt - base), 1);
    chk("R8 full panels mask", 32'(capMask), 32'h9);
    chk("R8 group address", 32'(capAddr), 32'h300);
    chk("R8 panel 3 byte 7", 32'(capData[(3*PB+7)*8 +: 8]), 32'(pat(3*PB+7)));
    finishOp();
    doReset();
    loadPanel(12'h300, 1, PB); loadPanel(12'h300, 2, 3);
    regWrite(2'd0, 8'h84); unlockKeys(); regWrite(2'd0, 8'h86);
    chk("R8 partial panel refused", 32'({ctlReg[1], errFlag}), 32'h1);
  endtask

  initial begin
    testReset();
    testEraseFlow();
    testNoKey();
    testBrokenKey();
    testEnableOrder();
    testSelects();
    testSinglePanel();
    testMultiPanel();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule